// File: doc/BRIEF.md
# Dead-Time Insertion with Grouped Update

This block sits after a PWM modulator and turns each channel's pair of reference timing strobes into a single output. The output rises a programmable number of clock cycles after one strobe and falls a programmable number of cycles after a strobe. Each channel has two select bits. One picks which strobe starts the rising delay, and the other picks which strobe starts the falling delay. The counters run on a clock whose period is one delay step of 1.25 ns, so an 8-bit delay spans 0 to 318.75 ns.

Software programs each channel through one 32-bit word. Writes land in a shadow copy. The shadow values of every channel move into the active set on a single clock edge, and that happens only when the word of the highest-numbered channel is written. Several channels can therefore be retimed without an intermediate mix of old and new delays. A delay that is already counting keeps the value it loaded when its strobe arrived, so a commit never shortens or stretches an edge in flight. Each channel keeps one pending edge. A newer strobe replaces any edge that has not yet been produced.

Top module: `deadtime_grouped`

## Requirements
- R1: While reset is high and on the first cycle after it, every output is 0, every register reads 0, and all active delays and selects are 0.
- R2: Channel word layout: rising delay in bits [7:0], falling delay in [15:8], rise select in bit 16 and fall select in bit 17 (0 = strobe t1, 1 = strobe t2). Other bits read 0, and a read returns the shadow value.
- R3: A write to any channel other than the last changes only that channel's shadow word; the active timing of every channel is unchanged.
- R4: A write to the last channel (byte address 4*(NCH-1)) copies all shadow words, including the one being written, into the active set on the same edge. Active values change on no other write.
- R5: When a rise strobe is sampled at clock edge k, the output goes high at edge k+rise_delay. A delay of 0 sets it at edge k itself.
- R6: When a fall strobe is sampled at edge k, the output goes low at edge k+fall_delay. A delay of 0 clears it at edge k itself.
- R7: The strobe that is not selected for an edge has no effect on that edge.
- R8: A rise or fall strobe that arrives while an earlier edge is still pending cancels the pending edge, and timing restarts from the new strobe.
- R9: If the rise strobe and the fall strobe of a channel are both present on the same edge, only the fall strobe takes effect.
- R10: A pending edge completes with the delay it loaded at its strobe, even if a commit changes the active delays while it counts.
- R11: A write to a misaligned address, or to one beyond the last channel, changes no register. A read at such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Delay clock, one period per delay step |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register word at reg_addr |
| reg_addr | input | ADDR_W | Byte address; channel i at 4*i |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Shadow word at reg_addr, combinational |
| ev_t1 | input | NCH | First reference strobe per channel |
| ev_t2 | input | NCH | Second reference strobe per channel |
| pwm_out | output | NCH | Dead-time adjusted outputs |

## Verification
The assertions check four rules on every cycle. Reset clears the outputs. The active set moves only after a write to the last channel's word. Writes to invalid addresses leave every shadow word untouched. A zero delay applies its edge on the very edge where its strobe is sampled, with the fall strobe winning when both strobes arrive together. Delay lengths, restarting on a newer strobe, strobes that are ignored under the select bits, and edges that finish with their original delay across a commit all depend on sequences that take many cycles. The bench shows these by sweeping delay pairs over every channel and timing the edges arithmetically.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    localparam int DLY_W    = 8;
    localparam int REG_W    = 32;
    localparam int RSEL_BIT = 2 * DLY_W;
    localparam int FSEL_BIT = 2 * DLY_W + 1;

    typedef struct packed {
        logic             fall_sel;
        logic             rise_sel;
        logic [DLY_W-1:0] fall_dly;
        logic [DLY_W-1:0] rise_dly;
    } chan_cfg_t;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_RISE = 2'd1,
        ENG_FALL = 2'd2
    } eng_state_t;

    function automatic chan_cfg_t cfg_unpack(input logic [REG_W-1:0] w);
        chan_cfg_t c;
        c.rise_dly = w[DLY_W-1:0];
        c.fall_dly = w[2*DLY_W-1:DLY_W];
        c.rise_sel = w[RSEL_BIT];
        c.fall_sel = w[FSEL_BIT];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] cfg_pack(input chan_cfg_t c);
        logic [REG_W-1:0] w;
        w                   = '0;
        w[DLY_W-1:0]        = c.rise_dly;
        w[2*DLY_W-1:DLY_W]  = c.fall_dly;
        w[RSEL_BIT]         = c.rise_sel;
        w[FSEL_BIT]         = c.fall_sel;
        return w;
    endfunction

endpackage

// File: rtl/dtg_regbank.sv
module dtg_regbank
    import dtg_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [REG_W-1:0]      wdata,
    output logic [REG_W-1:0]      rdata,
    output chan_cfg_t [NCH-1:0]   shd_cfg,
    output chan_cfg_t [NCH-1:0]   act_cfg
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]    idx;
    logic                hit;
    logic                commit;
    chan_cfg_t [NCH-1:0] shd_nxt;

    assign idx    = addr[ADDR_W-1:2];
    assign hit    = (addr[1:0] == 2'b00) && (int'(idx) < NCH);
    assign commit = wr_en && hit && (int'(idx) == NCH - 1);

    // Next shadow values: the addressed word takes the write data.
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            if (wr_en && hit && (int'(idx) == i)) begin
                shd_nxt[i] = cfg_unpack(wdata);
            end else begin
                shd_nxt[i] = shd_cfg[i];
            end
        end
    end

    // The commit copies the next shadow set so the last word joins the group.
    always_ff @(posedge clk) begin
        if (rst) begin
            shd_cfg <= '0;
            act_cfg <= '0;
        end else begin
            shd_cfg <= shd_nxt;
            if (commit) begin
                act_cfg <= shd_nxt;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (hit && (int'(idx) == i)) begin
                rdata = cfg_pack(shd_cfg[i]);
            end
        end
    end

endmodule

// File: rtl/dtg_edge_engine.sv
module dtg_edge_engine
    import dtg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ev_t1,
    input  logic      ev_t2,
    input  chan_cfg_t cfg,
    output logic      pwm_q
);

    logic             rise_ev;
    logic             fall_ev;
    eng_state_t       state;
    logic [DLY_W-1:0] cnt;

    assign rise_ev = cfg.rise_sel ? ev_t2 : ev_t1;
    assign fall_ev = cfg.fall_sel ? ev_t2 : ev_t1;

    // One pending edge per channel; a new strobe replaces it. The count is
    // loaded at the strobe, so later changes to cfg do not touch it.
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ENG_IDLE;
            cnt   <= '0;
            pwm_q <= 1'b0;
        end else if (fall_ev) begin
            if (cfg.fall_dly == '0) begin
                pwm_q <= 1'b0;
                state <= ENG_IDLE;
            end else begin
                state <= ENG_FALL;
                cnt   <= cfg.fall_dly;
            end
        end else if (rise_ev) begin
            if (cfg.rise_dly == '0) begin
                pwm_q <= 1'b1;
                state <= ENG_IDLE;
            end else begin
                state <= ENG_RISE;
                cnt   <= cfg.rise_dly;
            end
        end else if (state != ENG_IDLE) begin
            if (cnt == DLY_W'(1)) begin
                pwm_q <= (state == ENG_RISE);
                state <= ENG_IDLE;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/deadtime_grouped.sv
module deadtime_grouped
    import dtg_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [NCH-1:0]    ev_t1,
    input  logic [NCH-1:0]    ev_t2,
    output logic [NCH-1:0]    pwm_out
);

    chan_cfg_t [NCH-1:0] shd_cfg;
    chan_cfg_t [NCH-1:0] act_cfg;

    dtg_regbank #(
        .NCH    (NCH),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .shd_cfg (shd_cfg),
        .act_cfg (act_cfg)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        dtg_edge_engine u_eng (
            .clk   (clk),
            .rst   (rst),
            .ev_t1 (ev_t1[g]),
            .ev_t2 (ev_t2[g]),
            .cfg   (act_cfg[g]),
            .pwm_q (pwm_out[g])
        );
    end

endmodule

// File: rtl/dtg_checker.sv
module dtg_checker
    import dtg_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                reg_wr,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [NCH-1:0]      ev_t1,
    input logic [NCH-1:0]      ev_t2,
    input logic [NCH-1:0]      pwm_out,
    input chan_cfg_t [NCH-1:0] shd_cfg,
    input chan_cfg_t [NCH-1:0] act_cfg
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(4 * (NCH - 1));

    logic bad_addr;
    assign bad_addr = (reg_addr[1:0] != 2'b00) || (int'(reg_addr[ADDR_W-1:2]) >= NCH);

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (pwm_out == '0));

    // R4
    commit_only_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_cfg) |-> $past(reg_wr && (reg_addr == LAST_ADDR)));

    // R11
    bad_write_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && bad_addr) |=> $stable(shd_cfg));

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        logic rs_ev;
        logic fs_ev;
        assign rs_ev = act_cfg[g].rise_sel ? ev_t2[g] : ev_t1[g];
        assign fs_ev = act_cfg[g].fall_sel ? ev_t2[g] : ev_t1[g];

        // R5
        zero_rise_chk: assert property (@(posedge clk) disable iff (rst)
            (rs_ev && !fs_ev && (act_cfg[g].rise_dly == '0)) |=> pwm_out[g]);

        // R6 R9
        zero_fall_chk: assert property (@(posedge clk) disable iff (rst)
            (fs_ev && (act_cfg[g].fall_dly == '0)) |=> !pwm_out[g]);
    end

endmodule

bind deadtime_grouped dtg_checker #(
    .NCH    (NCH),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .ev_t1    (ev_t1),
    .ev_t2    (ev_t2),
    .pwm_out  (pwm_out),
    .shd_cfg  (shd_cfg),
    .act_cfg  (act_cfg)
);

// File: tb/deadtime_grouped_tb.sv
module deadtime_grouped_tb;

    localparam int NCH    = 4;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [NCH-1:0]    ev_t1 = '0;
    logic [NCH-1:0]    ev_t2 = '0;
    logic [NCH-1:0]    pwm_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    deadtime_grouped #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ev_t1     (ev_t1),
        .ev_t2     (ev_t2),
        .pwm_out   (pwm_out)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word(int dr, int df, bit rs, bit fs);
        return {14'd0, fs, rs, 8'(df), 8'(dr)};
    endfunction

    // All tasks start and end just after a falling edge.
    task automatic wr(int ch_addr, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = ADDR_W'(ch_addr); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        reg_addr = ADDR_W'(a);
        #1 d = reg_rdata;
    endtask

    task automatic pulse(int ch, bit second);
        if (second) ev_t2[ch] = 1'b1; else ev_t1[ch] = 1'b1;
        @(negedge clk);
        ev_t1 = '0; ev_t2 = '0;
    endtask

    task automatic wait_lvl(int ch, bit lvl, output int n);
        n = 0;
        while (pwm_out[ch] !== lvl && n < 300) begin
            @(negedge clk);
            n++;
        end
        if (pwm_out[ch] !== lvl) n = -1;
    endtask

    task automatic hold_lvl(int ch, bit lvl, int cyc, string req);
        bit ok = 1'b1;
        for (int k = 0; k < cyc; k++) begin
            if (pwm_out[ch] !== lvl) ok = 1'b0;
            @(negedge clk);
        end
        check(ok, req, pwm_out[ch], lvl);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        logic [31:0] d;
        int dl[6] = '{0, 1, 2, 3, 5, 9};

        repeat (3) @(negedge clk);
        check(pwm_out == '0, "R1 outputs in reset", pwm_out, 0);
        rst = 1'b0;
        check(pwm_out == '0, "R1 outputs after reset", pwm_out, 0);
        for (int c = 0; c < NCH; c++) begin
            rd(4 * c, d);
            check(d == 0, "R1 read after reset", d, 0);
        end
        @(negedge clk);

        // R2 layout and unused bits
        wr(0, 32'hFFF3_A55A);
        rd(0, d);
        check(d == 32'h0003_A55A, "R2 readback", d, 32'h0003_A55A);

        // R11 bad addresses
        wr(2, 32'h0000_1111);
        wr(4 * NCH, 32'h0000_2222);
        rd(0, d);
        check(d == 32'h0003_A55A, "R11 misaligned write", d, 32'h0003_A55A);
        rd(4 * NCH, d);
        check(d == 0, "R11 out of range read", d, 0);
        rd(4 * (NCH - 1), d);
        check(d == 0, "R11 last word untouched", d, 0);

        // R3 / R4: commit A, stage B, observe A until commit
        wr(0, word(2, 2, 0, 1));
        wr(4 * (NCH - 1), 0);
        wr(0, word(6, 2, 0, 1));
        rd(0, d);
        check(d == word(6, 2, 0, 1), "R2 read returns shadow", d, word(6, 2, 0, 1));
        pulse(0, 0); wait_lvl(0, 1, n);
        check(n == 2, "R3 staged value not active", n, 2);
        pulse(0, 1); wait_lvl(0, 0, n);
        check(n == 2, "R6 fall before commit", n, 2);
        wr(4 * (NCH - 1), 0);
        pulse(0, 0); wait_lvl(0, 1, n);
        check(n == 6, "R4 commit applies staged", n, 6);
        pulse(0, 1); wait_lvl(0, 0, n);

        // R5 / R6 sweep over channels and delay pairs
        for (int c = 0; c < NCH; c++) begin
            for (int i = 0; i < 6; i++) begin
                wr(4 * c, word(dl[i], dl[5 - i], 0, 1));
                if (c != NCH - 1) wr(4 * (NCH - 1), 0);
                pulse(c, 0); wait_lvl(c, 1, n);
                check(n == dl[i], "R5 rise delay", n, dl[i]);
                pulse(c, 1); wait_lvl(c, 0, n);
                check(n == dl[5 - i], "R6 fall delay", n, dl[5 - i]);
            end
            wr(4 * c, 0);
        end
        wr(4 * (NCH - 1), 0);

        // R7 swapped selects on channel 2
        wr(8, word(2, 3, 1, 0));
        wr(4 * (NCH - 1), 0);
        pulse(2, 0);
        hold_lvl(2, 0, 10, "R7 t1 does not raise");
        pulse(2, 1); wait_lvl(2, 1, n);
        check(n == 2, "R7 rise from t2", n, 2);
        pulse(2, 1);
        hold_lvl(2, 1, 10, "R7 t2 does not lower");
        pulse(2, 0); wait_lvl(2, 0, n);
        check(n == 3, "R7 fall from t1", n, 3);

        // R8 restart behaviour on channel 0
        wr(0, word(10, 4, 0, 1));
        wr(4 * (NCH - 1), 0);
        pulse(0, 0);
        repeat (3) @(negedge clk);
        pulse(0, 0); wait_lvl(0, 1, n);
        check(n == 10, "R8 rise restarts", n, 10);
        pulse(0, 1);
        pulse(0, 0);
        hold_lvl(0, 1, 15, "R8 fall cancelled by rise");
        pulse(0, 1); wait_lvl(0, 0, n);
        check(n == 4, "R8 fall after restart", n, 4);
        pulse(0, 0);
        repeat (2) @(negedge clk);
        pulse(0, 1);
        hold_lvl(0, 0, 20, "R8 rise cancelled by fall");

        // R9 both strobes together on channel 1
        wr(4, word(0, 0, 0, 0));
        wr(4 * (NCH - 1), 0);
        pulse(1, 0);
        check(pwm_out[1] == 1'b0, "R9 fall wins zero delay", pwm_out[1], 0);
        wr(4, word(0, 5, 0, 0));
        wr(4 * (NCH - 1), 0);
        pulse(1, 0);
        hold_lvl(1, 0, 10, "R9 fall wins with delay");

        // R10 commit during a pending rise on channel 0
        wr(0, word(8, 0, 0, 1));
        wr(4 * (NCH - 1), 0);
        wr(0, word(1, 0, 0, 1));
        pulse(0, 0);
        repeat (2) @(negedge clk);
        wr(4 * (NCH - 1), 0);
        wait_lvl(0, 1, n);
        check(n + 3 == 8, "R10 pending keeps delay", n + 3, 8);
        pulse(0, 1); wait_lvl(0, 0, n);
        pulse(0, 0); wait_lvl(0, 1, n);
        check(n == 1, "R4 new delay after commit", n, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule